// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block stands between a set of interrupt request lines and a processor core. For each line it holds a programmable priority, a vector address and a source selection. The selection picks a fixed-function source, a DMA request, a routed digital signal taken as a level, or the same routed signal passed through a rising-edge detector. A rising edge on the selected signal, or a software set command, makes the line pending. Among the enabled pending lines the controller picks the most urgent one. If that line outranks the interrupt service routine now running, the controller raises a request and presents the line's number and vector address.

The core reports two events: entry into a routine, which consumes the presented request, and exit from the innermost routine. Entry clears the pending bit and marks the line active. Edges that arrive while the routine runs collapse into a single new pending request. At exit, a line whose selected signal is still high becomes pending again, so a level source is serviced for as long as it is asserted. Routines nest: a strictly higher priority line may preempt a running one. Configuration is written through a simple single-cycle write port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every line is disabled, has priority 7, vector 0 and source mode 0 (fixed), and `irq_req` is low. A disabled line that becomes pending is presented once it is enabled.
- R2: A rising edge on a line's selected signal sets its pending bit. In the cycle after that clock edge, `irq_req` is high with `irq_line` and `irq_vector` showing that line, when it is the winner.
- R3: Source mode encoding in the control field bits [1:0]: 0 fixed-function input, 1 DMA request input, 2 routed input as level, 3 routed input through a rising-edge detector. Inputs that are not selected have no effect.
- R4: In mode 3 a routed pulse one clock wide is captured. A routed signal held high in mode 3 gives exactly one request and is not pended again at routine exit.
- R5: `isr_enter` while `irq_req` is high clears the presented line's pending bit and marks it active. `isr_enter` while `irq_req` is low is ignored.
- R6: Any number of edges on a line while its routine runs leave one pending request, which is presented after that routine exits.
- R7: A line whose selected signal is high when `isr_exit` closes its routine is pending again in the next cycle.
- R8: The pending, enabled line with the numerically lowest priority wins. On equal priority the lowest line number wins.
- R9: A line is presented only when its priority value is strictly below that of every active routine. `isr_exit` closes the active routine with the lowest priority value, and it is ignored when none is active.
- R10: A line whose enable bit (control field bit 2) is clear can become pending but is never presented.
- R11: Writing field 3 (pending set) to a line sets its pending bit. Field codes: 0 vector, 1 priority (data bits [2:0]), 2 control, 3 pending set.
- R12: A vector write takes effect on `irq_vector` in the cycle after the write, even while that line is being presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fixed_src | input | 32 | Fixed-function request per line |
| dma_src | input | 32 | DMA request per line |
| routed_src | input | 32 | Routed digital signal per line |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_line | input | 5 | Line targeted by the write |
| cfg_field | input | 2 | Field code: 0 vector, 1 priority, 2 control, 3 pending set |
| cfg_wdata | input | 16 | Write data |
| isr_enter | input | 1 | Core has entered the routine of the presented line |
| isr_exit | input | 1 | Core has left its innermost routine |
| irq_req | output | 1 | Request to the core |
| irq_line | output | 5 | Number of the presented line |
| irq_vector | output | 16 | Vector address of the presented line |

## Verification
The assertions assume that every source input and every core acknowledge is synchronous to `clk`. They also assume that `isr_exit` refers to the routine the core actually runs innermost. The stimulus changes inputs only just after a rising edge. It pulses `isr_enter` only while a request is shown, except in the deliberate ignore case, and it issues exits in nesting order. Priority, enable and mode writes happen while the affected line is quiet, so a mode switch never creates an edge the checks do not expect.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    SRC_FIXED       = 2'd0,
    SRC_DMA         = 2'd1,
    SRC_ROUTED      = 2'd2,
    SRC_ROUTED_EDGE = 2'd3
  } src_mode_e;

  typedef enum logic [1:0] {
    FLD_VECTOR   = 2'd0,
    FLD_PRIO     = 2'd1,
    FLD_CTRL     = 2'd2,
    FLD_PEND_SET = 2'd3
  } cfg_field_e;

  localparam int CTRL_EN_BIT = 2;

endpackage

// File: rtl/irq_src_select.sv
module irq_src_select
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_LINES-1:0]      fixed_src,
  input  logic [NUM_LINES-1:0]      dma_src,
  input  logic [NUM_LINES-1:0]      routed_src,
  input  logic [NUM_LINES-1:0][1:0] mode,
  output logic [NUM_LINES-1:0]      line_sig,
  output logic [NUM_LINES-1:0]      line_rise
);

  logic [NUM_LINES-1:0] routed_q;
  logic [NUM_LINES-1:0] line_q;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic edge_pulse;
    assign edge_pulse = routed_src[g] & ~routed_q[g];

    always_comb begin
      unique case (src_mode_e'(mode[g]))
        SRC_FIXED:       line_sig[g] = fixed_src[g];
        SRC_DMA:         line_sig[g] = dma_src[g];
        SRC_ROUTED:      line_sig[g] = routed_src[g];
        SRC_ROUTED_EDGE: line_sig[g] = edge_pulse;
        default:         line_sig[g] = 1'b0;
      endcase
    end

    assign line_rise[g] = line_sig[g] & ~line_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      routed_q <= '0;
      line_q   <= '0;
    end else begin
      routed_q <= routed_src;
      line_q   <= line_sig;
    end
  end

endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_W     = 16,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [IDX_W-1:0]                 addr,
  input  logic [1:0]                       field,
  input  logic [VEC_W-1:0]                 wdata,
  output logic [NUM_LINES-1:0][VEC_W-1:0]  vec,
  output logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  output logic [NUM_LINES-1:0][1:0]        mode,
  output logic [NUM_LINES-1:0]             en,
  output logic [NUM_LINES-1:0]             sw_set
);

  logic [NUM_LINES-1:0][VEC_W-1:0]  vec_q,  vec_n;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_q, prio_n;
  logic [NUM_LINES-1:0][1:0]        mode_q, mode_n;
  logic [NUM_LINES-1:0]             en_q,   en_n;
  logic                             addr_ok;

  assign addr_ok = (int'(addr) < NUM_LINES);

  always_comb begin
    vec_n  = vec_q;
    prio_n = prio_q;
    mode_n = mode_q;
    en_n   = en_q;
    sw_set = '0;
    if (we && addr_ok) begin
      unique case (cfg_field_e'(field))
        FLD_VECTOR:   vec_n[addr]  = wdata;
        FLD_PRIO:     prio_n[addr] = wdata[PRIO_W-1:0];
        FLD_CTRL: begin
          mode_n[addr] = wdata[1:0];
          en_n[addr]   = wdata[CTRL_EN_BIT];
        end
        FLD_PEND_SET: sw_set[addr] = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      prio_q <= '1;
      mode_q <= '0;
      en_q   <= '0;
    end else if (we) begin
      vec_q  <= vec_n;
      prio_q <= prio_n;
      mode_q <= mode_n;
      en_q   <= en_n;
    end
  end

  assign vec  = vec_q;
  assign prio = prio_q;
  assign mode = mode_q;
  assign en   = en_q;

  AST_SWSET_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sw_set)); // R11

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0]             pend,
  input  logic [NUM_LINES-1:0]             en,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  input  logic [PRIO_W:0]                  act_prio,
  output logic                             req,
  output logic [IDX_W-1:0]                 win_idx
);

  logic [NUM_LINES-1:0] elig;
  logic                 found;
  logic [PRIO_W-1:0]    best_prio;

  assign elig = pend & en;

  always_comb begin
    found     = 1'b0;
    best_prio = '1;
    win_idx   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (elig[i] && (!found || prio[i] < best_prio)) begin
        found     = 1'b1;
        best_prio = prio[i];
        win_idx   = i[IDX_W-1:0];
      end
    end
  end

  assign req = found && ({1'b0, best_prio} < act_prio);

endmodule

// File: rtl/irq_state.sv
module irq_state #(
  parameter int NUM_LINES = 32,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_LINES-1:0]             set_vec,
  input  logic [NUM_LINES-1:0]             line_sig,
  input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
  input  logic                             isr_enter,
  input  logic                             isr_exit,
  input  logic                             req,
  input  logic [IDX_W-1:0]                 ack_line,
  output logic [NUM_LINES-1:0]             pend,
  output logic [PRIO_W:0]                  act_prio
);

  logic [NUM_LINES-1:0] pend_q,   pend_n;
  logic [NUM_LINES-1:0] active_q, active_n;
  logic                 top_found;
  logic [PRIO_W-1:0]    top_prio;
  logic [IDX_W-1:0]     top_idx;
  logic                 enter_ok;
  logic                 exit_ok;

  always_comb begin
    top_found = 1'b0;
    top_prio  = '1;
    top_idx   = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (active_q[i] && (!top_found || prio[i] < top_prio)) begin
        top_found = 1'b1;
        top_prio  = prio[i];
        top_idx   = i[IDX_W-1:0];
      end
    end
  end

  assign act_prio = top_found ? {1'b0, top_prio} : {1'b1, {PRIO_W{1'b0}}};
  assign enter_ok = isr_enter && req;
  assign exit_ok  = isr_exit && top_found;

  always_comb begin
    pend_n   = pend_q;
    active_n = active_q;
    if (exit_ok) begin
      active_n[top_idx] = 1'b0;
      if (line_sig[top_idx]) pend_n[top_idx] = 1'b1;
    end
    if (enter_ok) begin
      active_n[ack_line] = 1'b1;
      pend_n[ack_line]   = 1'b0;
    end
    pend_n = pend_n | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= '0;
      active_q <= '0;
    end else begin
      pend_q   <= pend_n;
      active_q <= active_n;
    end
  end

  assign pend = pend_q;

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((pend_q & $past(set_vec)) == $past(set_vec))); // R2

  AST_ENTER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_ok && !set_vec[ack_line]) |=> (!pend_q[$past(ack_line)] && active_q[$past(ack_line)])); // R5

  AST_ENTER_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_enter && !req && !isr_exit) |=> $stable(active_q)); // R5

  AST_EXIT_REPEND: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_ok && line_sig[top_idx]) |=> pend_q[$past(top_idx)]); // R7

  AST_EXIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_exit && !top_found && !isr_enter) |=> (active_q == '0)); // R9

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int VEC_W     = 16,
  parameter int PRIO_W    = 3,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] fixed_src,
  input  logic [NUM_LINES-1:0] dma_src,
  input  logic [NUM_LINES-1:0] routed_src,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_line,
  input  logic [1:0]           cfg_field,
  input  logic [VEC_W-1:0]     cfg_wdata,
  input  logic                 isr_enter,
  input  logic                 isr_exit,
  output logic                 irq_req,
  output logic [IDX_W-1:0]     irq_line,
  output logic [VEC_W-1:0]     irq_vector
);

  logic [NUM_LINES-1:0][VEC_W-1:0]  vec;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
  logic [NUM_LINES-1:0][1:0]        mode;
  logic [NUM_LINES-1:0]             en;
  logic [NUM_LINES-1:0]             sw_set;
  logic [NUM_LINES-1:0]             line_sig;
  logic [NUM_LINES-1:0]             line_rise;
  logic [NUM_LINES-1:0]             pend;
  logic [PRIO_W:0]                  act_prio;
  logic                             req;
  logic [IDX_W-1:0]                 win_idx;

  irq_cfg_regs #(
    .NUM_LINES(NUM_LINES), .VEC_W(VEC_W), .PRIO_W(PRIO_W)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_line),
    .field(cfg_field), .wdata(cfg_wdata), .vec(vec), .prio(prio),
    .mode(mode), .en(en), .sw_set(sw_set)
  );

  irq_src_select #(
    .NUM_LINES(NUM_LINES)
  ) u_src (
    .clk(clk), .rst_n(rst_n), .fixed_src(fixed_src), .dma_src(dma_src),
    .routed_src(routed_src), .mode(mode), .line_sig(line_sig),
    .line_rise(line_rise)
  );

  irq_state #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .set_vec(line_rise | sw_set),
    .line_sig(line_sig), .prio(prio), .isr_enter(isr_enter),
    .isr_exit(isr_exit), .req(req), .ack_line(win_idx),
    .pend(pend), .act_prio(act_prio)
  );

  irq_arbiter #(
    .NUM_LINES(NUM_LINES), .PRIO_W(PRIO_W)
  ) u_arb (
    .pend(pend), .en(en), .prio(prio), .act_prio(act_prio),
    .req(req), .win_idx(win_idx)
  );

  assign irq_req    = req;
  assign irq_line   = win_idx;
  assign irq_vector = vec[win_idx];

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (en[irq_line] && pend[irq_line])); // R10

  AST_REQ_ABOVE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ({1'b0, prio[irq_line]} < act_prio)); // R9

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_chk
    AST_NO_BETTER: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req && pend[g] && en[g]) |->
        ((prio[g] > prio[irq_line]) ||
         (prio[g] == prio[irq_line] && g >= int'(irq_line)))); // R8
  end

endmodule

// File: tb/irq_vector_ctrl_tb.sv
module irq_vector_ctrl_tb;

  typedef struct {
    logic        req;
    logic [4:0]  line;
    logic [15:0] vec;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] fixed_src, dma_src, routed_src;
  logic        cfg_we;
  logic [4:0]  cfg_line;
  logic [1:0]  cfg_field;
  logic [15:0] cfg_wdata;
  logic        isr_enter, isr_exit;
  logic        irq_req;
  logic [4:0]  irq_line;
  logic [15:0] irq_vector;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fails  = 0;
  bit   done     = 0;

  always #5 clk = ~clk;

  irq_vector_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .fixed_src(fixed_src), .dma_src(dma_src),
    .routed_src(routed_src), .cfg_we(cfg_we), .cfg_line(cfg_line),
    .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .isr_enter(isr_enter),
    .isr_exit(isr_exit), .irq_req(irq_req), .irq_line(irq_line),
    .irq_vector(irq_vector)
  );

  // monitor: pops expected items and compares away from the active edge
  always @(negedge clk) begin
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (irq_req !== e.req || (e.req && (irq_line !== e.line || irq_vector !== e.vec))) begin
        n_fails++;
        $display("FAIL %s: req=%0b line=%0d vec=%h expected req=%0b line=%0d vec=%h",
                 e.tag, irq_req, irq_line, irq_vector, e.req, e.line, e.vec);
      end
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic req, input int line, input int vec, input string tag);
    exp_t e;
    e.req = req; e.line = line[4:0]; e.vec = vec[15:0]; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic wr(input int line, input int field, input int data);
    cfg_we = 1'b1; cfg_line = line[4:0]; cfg_field = field[1:0]; cfg_wdata = data[15:0];
    step();
    cfg_we = 1'b0;
  endtask

  task automatic enter();
    isr_enter = 1'b1; step(); isr_enter = 1'b0;
  endtask

  task automatic leave();
    isr_exit = 1'b1; step(); isr_exit = 1'b0;
  endtask

  task automatic setup(input int line, input int vec, input int pr, input int ctrl);
    wr(line, 0, vec);
    wr(line, 1, pr);
    wr(line, 2, ctrl);
  endtask

  initial begin
    rst_n = 1'b0; fixed_src = '0; dma_src = '0; routed_src = '0;
    cfg_we = 1'b0; cfg_line = '0; cfg_field = '0; cfg_wdata = '0;
    isr_enter = 1'b0; isr_exit = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    expect_out(0, 0, 0, "R1 reset idle");

    // R1: line 1 disabled by default, pends, shows once enabled with vector 0
    fixed_src[1] = 1'b1; step();
    expect_out(0, 0, 0, "R1 disabled after reset");
    wr(1, 2, 4);
    expect_out(1, 1, 0, "R1 enable presents pending");
    enter(); fixed_src[1] = 1'b0; leave();
    expect_out(0, 0, 0, "R1 serviced");

    // R5: enter with no request is ignored (line 0 prio 0 would block all)
    wr(0, 1, 0);
    enter();
    setup(3, 'h1003, 2, 4);
    fixed_src[3] = 1'b1; step();
    expect_out(1, 3, 'h1003, "R2 R5 edge request after ignored enter");
    enter();
    expect_out(0, 0, 0, "R5 enter clears pending");
    leave();
    expect_out(1, 3, 'h1003, "R7 level still high repended");
    enter(); fixed_src[3] = 1'b0; leave();
    expect_out(0, 0, 0, "R7 level low not repended");

    // R3: DMA mode, fixed input ignored
    setup(5, 'h0505, 4, 5);
    fixed_src[5] = 1'b1; step();
    expect_out(0, 0, 0, "R3 unselected source ignored");
    dma_src[5] = 1'b1; step();
    expect_out(1, 5, 'h0505, "R3 dma source selected");
    enter(); dma_src[5] = 1'b0; leave();
    fixed_src[5] = 1'b0;
    expect_out(0, 0, 0, "R3 serviced");

    // R4: edge-detected routed mode
    setup(7, 'h0707, 3, 7);
    routed_src[7] = 1'b1; step(); routed_src[7] = 1'b0;
    expect_out(1, 7, 'h0707, "R4 one-cycle pulse captured");
    enter(); leave();
    expect_out(0, 0, 0, "R4 pulse serviced once");
    routed_src[7] = 1'b1; step();
    expect_out(1, 7, 'h0707, "R4 held edge request");
    enter(); leave();
    expect_out(0, 0, 0, "R4 held edge not repended");
    routed_src[7] = 1'b0; step();

    // R6: edges during ISR collapse
    routed_src[7] = 1'b1; step(); routed_src[7] = 1'b0;
    expect_out(1, 7, 'h0707, "R6 first edge");
    enter();
    for (int k = 0; k < 3; k++) begin
      routed_src[7] = 1'b1; step(); routed_src[7] = 1'b0; step();
    end
    expect_out(0, 0, 0, "R6 R9 same priority blocked");
    leave();
    expect_out(1, 7, 'h0707, "R6 collapsed request after exit");
    enter(); leave();
    expect_out(0, 0, 0, "R6 only one extra request");

    // R8 / R9: priority, ties, nesting
    setup(10, 'h0A0A, 5, 6);
    setup(11, 'h0B0B, 1, 6);
    setup(12, 'h0C0C, 1, 6);
    routed_src[12:10] = 3'b111; step();
    expect_out(1, 11, 'h0B0B, "R8 tie lowest index");
    enter();
    expect_out(0, 0, 0, "R9 equal priority not presented");
    routed_src[12:10] = 3'b000;
    leave();
    expect_out(1, 12, 'h0C0C, "R8 next equal priority");
    enter(); leave();
    expect_out(1, 10, 'h0A0A, "R8 lower priority last");
    enter();
    fixed_src[3] = 1'b1; step();
    expect_out(1, 3, 'h1003, "R9 preemption by higher priority");
    enter(); fixed_src[3] = 1'b0; leave();
    routed_src[7] = 1'b1; step(); routed_src[7] = 1'b0;
    expect_out(1, 7, 'h0707, "R9 exit closed innermost routine");
    enter(); leave(); leave();
    expect_out(0, 0, 0, "R9 all routines closed");
    leave();
    expect_out(0, 0, 0, "R9 exit with none active ignored");
    fixed_src[3] = 1'b1; step();
    expect_out(1, 3, 'h1003, "R9 idle exit left no active state");
    enter(); fixed_src[3] = 1'b0; leave();

    // R10: disabled line pends, not presented
    wr(20, 0, 'h2020); wr(20, 1, 0); wr(20, 2, 2);
    routed_src[20] = 1'b1; step(); routed_src[20] = 1'b0; step();
    expect_out(0, 0, 0, "R10 disabled not presented");
    wr(20, 2, 6);
    expect_out(1, 20, 'h2020, "R10 enable shows held pending");
    enter(); leave();
    expect_out(0, 0, 0, "R10 serviced");

    // R11 / R12
    setup(31, 'hABCD, 6, 4);
    wr(31, 3, 0);
    expect_out(1, 31, 'hABCD, "R11 software pending set");
    wr(31, 0, 'h1234);
    expect_out(1, 31, 'h1234, "R12 vector rewrite visible");
    enter(); leave();
    expect_out(0, 0, 0, "R11 serviced");

    step(); step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: req=%0b expected completion", irq_req);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule